// File: doc/BRIEF.md
# Peripheral Interrupt Aggregator

This block merges ten peripheral interrupt lines into a single request toward the processor. The sources are four general-purpose I/O banks, three LED blink engines, an SPI port, an SMBus port and a one-wire port. A control register holds a master enable, an output-mode select and six group enable bits. A status vector always shows the raw level of every source, whatever the masking. Sources are cleared only at the peripheral that raised them.

The request can be driven in one of two ways. In level mode it is high for as long as any enabled source is high. In edge mode it gives a one-cycle pulse each time the combined enabled request goes from low to high. A second register drives a power-of-two prescaled tick that can be used for interrupt timing. That register has a 4-bit exponent, saturated at 14, and an enable bit.

Top module: `irq_aggregator`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it, the control readback, the timebase readback, the status vector, the request and the tick are all zero.
- R2: `status_o` bit i equals `src_irq_i` bit i as sampled at the previous clock edge. The control register has no effect on it. Bit order: 0..3 I/O banks A..D, 4..6 LED0..LED2, 7 SPI, 8 SMBus, 9 one-wire.
- R3: When control bit 0 (master enable, 1 = on) is 0, `cpu_irq_o` is low regardless of the sources.
- R4: A group enable bit of 1 lets its sources through. Control bits 2..5 enable status bits 0..3, bit 6 enables status bits 4..6, and bit 7 enables status bits 7..9. A source whose group bit is 0 never raises the request.
- R5: When control bit 1 is 0 (level mode), `cpu_irq_o` equals the enabled OR of the status vector one cycle later. That is two edges after the source changes.
- R6: When control bit 1 is 1 (edge mode), `cpu_irq_o` is high for exactly one cycle each time the enabled OR rises. A source that is held high produces only one pulse.
- R7: Timebase register: bits 3..0 hold the exponent and bit 4 is the enable. A written exponent above 14 reads back as 14.
- R8: With the timebase enabled and exponent n, `tick_o` is a one-cycle pulse every 2^n cycles. With it disabled, `tick_o` stays low.
- R9: A write with `cfg_sel_i` = 0 updates only the control register, and with `cfg_sel_i` = 1 only the timebase register. Both registers read back on their outputs one cycle after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_irq_i | input | 10 | Raw peripheral interrupt levels |
| cfg_wr_i | input | 1 | Register write strobe |
| cfg_sel_i | input | 1 | 0 = control register, 1 = timebase register |
| cfg_wdata_i | input | 8 | Write data |
| ctrl_o | output | 8 | Control register readback |
| tbase_o | output | 5 | Timebase register readback |
| status_o | output | 10 | Raw source status |
| cpu_irq_o | output | 1 | Combined interrupt request |
| tick_o | output | 1 | Prescaled timebase tick |

## Verification
The assertions assume that every source line is already synchronous to `clk` and is steady around each edge. They also assume that write data is valid whenever the strobe is high. The bench changes sources and write strobes only on the falling edge and holds them for at least one full cycle. Each edge-mode pulse is therefore caused by exactly one sampled rise. Sources are lowered between edge-mode pulses, so each new rise is a clean one.

// File: rtl/irq_agg_pkg.sv
// Package: shared sizes and the source-to-group map of the aggregator.
// Assumes a fixed ten-source layout; group bits sit at control bits 2..7.
package irq_agg_pkg;
    localparam int NUM_SRC      = 10;
    localparam int CTRL_W       = 8;
    localparam int GRP_W        = 6;
    localparam int PRESCALE_W   = 4;
    localparam int PRESCALE_MAX = 14;
    localparam int TBASE_W      = PRESCALE_W + 1;

    typedef enum logic {SEL_CTRL = 1'b0, SEL_TBASE = 1'b1} cfg_sel_e;

    // Index of the group enable bit (within control bits 7..2) for a source.
    function automatic int grp_of(input int src);
        if (src < 4)      return src;
        else if (src < 7) return 4;
        else              return 5;
    endfunction
endpackage

// File: rtl/irq_cfg_regs.sv
// Module: control and timebase registers.
// Holds the control byte and the timebase byte. It saturates the prescale
// exponent on write. Assumes the write data is valid while the strobe is high.
module irq_cfg_regs
    import irq_agg_pkg::*;
#(
    parameter int CW  = CTRL_W,
    parameter int PW  = PRESCALE_W,
    parameter int PMX = PRESCALE_MAX
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_i,
    input  logic          sel_i,
    input  logic [CW-1:0] wdata_i,
    output logic [CW-1:0] ctrl_o,
    output logic [PW:0]   tbase_o
);
    localparam logic [PW-1:0] PMAX = PW'(PMX);

    logic [PW-1:0] pre_clamped;

    // Saturate the requested exponent to its legal maximum.
    always_comb begin
        pre_clamped = (wdata_i[PW-1:0] > PMAX) ? PMAX : wdata_i[PW-1:0];
    end

    // Update the selected register on a write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_o  <= '0;
            tbase_o <= '0;
        end else if (wr_i) begin
            if (sel_i == SEL_CTRL) ctrl_o  <= wdata_i;
            else                   tbase_o <= {wdata_i[PW], pre_clamped};
        end
    end

    p_tbase_en_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && sel_i == SEL_TBASE) |=> (tbase_o[PW] == $past(wdata_i[PW])));

    p_ctrl_untouched_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && sel_i == SEL_TBASE) |=> $stable(ctrl_o));
endmodule

// File: rtl/irq_src_gate.sv
// Module: group masking of the sampled status vector.
// Each source is passed on when the enable bit of its group is set. The
// result is one OR of the passed sources. Purely combinational.
module irq_src_gate
    import irq_agg_pkg::*;
#(
    parameter int N  = NUM_SRC,
    parameter int GW = GRP_W
) (
    input  logic [N-1:0]  status_i,
    input  logic [GW-1:0] grp_en_i,
    output logic          any_o
);
    logic [N-1:0] pass;

    // One gate per source, each tied to the enable bit of its group.
    for (genvar i = 0; i < N; i++) begin : g_src
        localparam int G = grp_of(i);
        assign pass[i] = status_i[i] & grp_en_i[G];
    end

    // Combine every passed source into one request.
    always_comb begin
        any_o = |pass;
    end
endmodule

// File: rtl/irq_out_shaper.sv
// Module: output stage of the request.
// Level mode: registers the gated request. Edge mode: gives one pulse on
// each rise of it. Assumes gated_i is synchronous to clk.
module irq_out_shaper (
    input  logic clk,
    input  logic rst_n,
    input  logic enable_i,
    input  logic edge_mode_i,
    input  logic any_i,
    output logic irq_o
);
    logic gated;
    logic gated_q;

    // Apply the master enable before edge detection.
    always_comb begin
        gated = enable_i & any_i;
    end

    // Remember last cycle's gated request and drive the output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gated_q <= 1'b0;
            irq_o   <= 1'b0;
        end else begin
            gated_q <= gated;
            irq_o   <= edge_mode_i ? (gated & ~gated_q) : gated;
        end
    end

    p_disabled_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |=> !irq_o);

    p_level_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!edge_mode_i && enable_i && any_i) |=> irq_o);

    p_edge_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_mode_i && irq_o) |=> !irq_o);
endmodule

// File: rtl/irq_timebase.sv
// Module: power-of-two prescaled tick generator.
// When enabled with exponent n it pulses tick_o once every 2^n cycles. The
// counter is cleared while disabled. Assumes n never exceeds PMX.
module irq_timebase
    import irq_agg_pkg::*;
#(
    parameter int PW  = PRESCALE_W,
    parameter int PMX = PRESCALE_MAX
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_i,
    input  logic [PW-1:0] exp_i,
    output logic          tick_o
);
    localparam int CNT_W = PMX;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W:0]   span;
    logic [CNT_W-1:0] limit;

    // Last count value of the current period: 2^n - 1.
    always_comb begin
        span  = (CNT_W+1)'(1) << exp_i;
        limit = CNT_W'(span - (CNT_W+1)'(1));
    end

    // Count cycles and pulse when a period ends.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i) begin
            cnt    <= '0;
            tick_o <= 1'b0;
        end else if (cnt >= limit) begin
            cnt    <= '0;
            tick_o <= 1'b1;
        end else begin
            cnt    <= cnt + 1'b1;
            tick_o <= 1'b0;
        end
    end

    p_tick_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !tick_o);

    p_tick_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && en_i && exp_i != '0 && $stable(exp_i)) |=> !tick_o);
endmodule

// File: rtl/irq_aggregator.sv
// Module: top level of the interrupt aggregator.
// Samples the raw sources into the status vector, masks them by group and
// shapes the combined request. It also runs the prescaled timebase.
// Assumes the sources are already synchronous to clk.
module irq_aggregator
    import irq_agg_pkg::*;
#(
    parameter int N   = NUM_SRC,
    parameter int CW  = CTRL_W,
    parameter int PW  = PRESCALE_W,
    parameter int PMX = PRESCALE_MAX
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  src_irq_i,
    input  logic          cfg_wr_i,
    input  logic          cfg_sel_i,
    input  logic [CW-1:0] cfg_wdata_i,
    output logic [CW-1:0] ctrl_o,
    output logic [PW:0]   tbase_o,
    output logic [N-1:0]  status_o,
    output logic          cpu_irq_o,
    output logic          tick_o
);
    localparam int GW = CW - 2;

    logic any_req;

    irq_cfg_regs #(.CW(CW), .PW(PW), .PMX(PMX)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (cfg_wr_i),
        .sel_i   (cfg_sel_i),
        .wdata_i (cfg_wdata_i),
        .ctrl_o  (ctrl_o),
        .tbase_o (tbase_o)
    );

    // Capture the raw source levels; this vector is never masked.
    always_ff @(posedge clk) begin
        if (!rst_n) status_o <= '0;
        else        status_o <= src_irq_i;
    end

    irq_src_gate #(.N(N), .GW(GW)) u_gate (
        .status_i (status_o),
        .grp_en_i (ctrl_o[CW-1:2]),
        .any_o    (any_req)
    );

    irq_out_shaper u_shape (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable_i    (ctrl_o[0]),
        .edge_mode_i (ctrl_o[1]),
        .any_i       (any_req),
        .irq_o       (cpu_irq_o)
    );

    irq_timebase #(.PW(PW), .PMX(PMX)) u_tb (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (tbase_o[PW]),
        .exp_i  (tbase_o[PW-1:0]),
        .tick_o (tick_o)
    );

    p_status_raw_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (status_o == $past(src_irq_i)));

    p_no_source_no_irq_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o == '0) |=> !cpu_irq_o);
endmodule

// File: tb/irq_aggregator_test.sv
module irq_aggregator_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] src = '0;
    logic       wr = 1'b0;
    logic       sel = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] ctrl;
    logic [4:0] tbase;
    logic [9:0] status;
    logic       irq;
    logic       tick;
    int         n_chk = 0;
    int         n_fail = 0;

    always #2.5 clk = ~clk;

    irq_aggregator uut (
        .clk(clk), .rst_n(rst_n), .src_irq_i(src), .cfg_wr_i(wr),
        .cfg_sel_i(sel), .cfg_wdata_i(wdata), .ctrl_o(ctrl), .tbase_o(tbase),
        .status_o(status), .cpu_irq_o(irq), .tick_o(tick)
    );

    // {control byte, sources, expected request}; all in level mode.
    localparam logic [18:0] VEC [12] = '{
        {8'h00, 10'h3FF, 1'b0},  // R3 master off
        {8'hFD, 10'h000, 1'b0},  // R5 nothing pending
        {8'h05, 10'h001, 1'b1},  // R4 bank A enabled
        {8'h05, 10'h002, 1'b0},  // R4 bank B blocked
        {8'h09, 10'h002, 1'b1},  // R4 bank B enabled
        {8'h41, 10'h020, 1'b1},  // R4 LED group
        {8'h41, 10'h080, 1'b0},  // R4 serial group blocked
        {8'h81, 10'h200, 1'b1},  // R4 serial group
        {8'h81, 10'h070, 1'b0},  // R4 LED group blocked
        {8'h80, 10'h200, 1'b0},  // R3 master off
        {8'h21, 10'h008, 1'b1},  // R4 bank D
        {8'hFD, 10'h100, 1'b1}   // R5 all enabled
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic write(input logic s, input logic [7:0] d);
        wr = 1'b1; sel = s; wdata = d;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(5.0 * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%h expected=%h", 1'b1, 1'b0);
        report();
    end

    initial begin
        @(negedge clk); @(negedge clk);
        // R1 during reset
        check("R1", {ctrl, 3'b0, tbase}, 16'h0);
        check("R1", {4'b0, status, irq, tick}, 16'h0);
        src = 10'h3FF;
        rst_n = 1'b1;
        @(negedge clk);
        // R1 first cycle after reset; R2 status already sampled
        check("R1", {ctrl, 3'b0, tbase}, 16'h0);
        check("R2", 16'(status), 16'h3FF);
        src = '0;
        cycles(2);

        // Vector table, level mode
        for (int v = 0; v < 12; v++) begin
            wr = 1'b1; sel = 1'b0; wdata = VEC[v][18:11]; src = VEC[v][10:1];
            @(negedge clk);
            wr = 1'b0;
            check("R2", 16'(status), 16'(VEC[v][10:1]));
            check("R9", 16'(ctrl), 16'(VEC[v][18:11]));
            @(negedge clk);
            check("R5", 16'(irq), 16'(VEC[v][0]));
        end

        // R5 level request falls with the source
        src = '0;
        cycles(2);
        check("R5", 16'(irq), 16'h0);

        // R6 edge mode, bank A only
        write(1'b0, 8'h07);
        cycles(2);
        check("R6", 16'(irq), 16'h0);
        src = 10'h001;
        @(negedge clk);
        @(negedge clk);
        check("R6", 16'(irq), 16'h1);
        @(negedge clk);
        check("R6", 16'(irq), 16'h0);
        cycles(3);
        check("R6", 16'(irq), 16'h0);
        src = '0;
        cycles(3);
        src = 10'h001;
        cycles(2);
        check("R6", 16'(irq), 16'h1);
        @(negedge clk);
        check("R6", 16'(irq), 16'h0);
        src = '0;
        // R4 edge mode: blocked source gives no pulse
        cycles(3);
        src = 10'h004;
        cycles(2);
        check("R4", 16'(irq), 16'h0);
        src = '0;

        // R7 saturation and enable readback; R9 control unchanged
        write(1'b1, 8'h1F);
        check("R7", 16'(tbase), 16'h1E);
        check("R9", 16'(ctrl), 16'h07);

        // R8 period for exponent 2
        write(1'b1, 8'h12);
        begin
            int guard = 0;
            int gap = 0;
            while (!tick && guard < 50) begin @(negedge clk); guard++; end
            @(negedge clk); gap = 1;
            while (!tick && gap < 50) begin @(negedge clk); gap++; end
            check("R8", 16'(gap), 16'd4);
        end

        // R8 exponent 0: tick every cycle
        write(1'b1, 8'h10);
        cycles(2);
        check("R8", 16'(tick), 16'h1);
        @(negedge clk);
        check("R8", 16'(tick), 16'h1);

        // R8 disabled: no tick over a window
        write(1'b1, 8'h02);
        begin
            int seen = 0;
            for (int i = 0; i < 20; i++) begin @(negedge clk); seen += int'(tick); end
            check("R8", 16'(seen), 16'd0);
        end
        check("R7", 16'(tbase), 16'h02);

        // R1 reset in mid-run clears the registers
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", {ctrl, 3'b0, tbase}, 16'h0);
        check("R1", 16'(irq), 16'h0);

        report();
    end
endmodule